// File: doc/BRIEF.md
# System Error Fail-Code Reporter

This block watches a processor's fault sources and, on the first one it sees, signals the failure on a single pin. It then reports which faults occurred through one bus read. The low byte of the read address is an 8-bit fail code. The upper bytes of the address are a fixed pattern, so the code can be picked up with a bus analyser or a logic probe. After the read has been accepted, the block stops and stays stopped until reset.

There are two groups of fault inputs:
- five self-test result flags;
- three other faults: a misaligned structure in the initial memory image, a bus confidence test failure, and a runtime system error.

The top bit of the code says which group the mask bits describe. Detection stays armed for the whole time between reset and the first fault, not only during start-up.

Top module: `syserr_fail_reporter`

## Requirements
- R1: After reset and while no fault input has been seen, `fail_n` is 1, `rd_valid` is 0 and `halt` is 0.
- R2: A fault input that is high at a clock edge makes `fail_n` go to 0 and `rd_valid` go to 1 after that edge.
- R3: While `rd_valid` is 1, `rd_addr[31:8]` equals 0xFEFFFF and `rd_addr[7:0]` is the fail code.
- R4: When any self-test flag is set, code bit 7 is 1 and `bist_fail[k]` appears at code bit k+2. The flags map as follows:
  - k=4 is the data RAM;
  - k=3 is the microcode ROM;
  - k=2 is the instruction cache;
  - k=1 is the data cache;
  - k=0 is the local-register cache or core.
- R5: When no self-test flag is set, code bit 7 is 0 and bits 6 and 5 are 1. Bit 4 is `img_misalign`, bit 3 is `sys_err` and bit 2 is `bus_conf_fail`.
- R6: Code bits 1 and 0 are always 0.
- R7: When self-test flags and other faults arrive in the same cycle, only the self-test form of R4 is reported.
- R8: `rd_valid` stays 1 with an unchanged `rd_addr` until a cycle in which `rd_ready` is 1.
- R9: After the read is accepted, `rd_valid` never rises again and `halt` is 1. `fail_n` stays 0 until reset.
- R10: Fault inputs that arrive after the first detection do not change the reported code.
- R11: A fault that arrives after any number of idle cycles following reset is detected the same way as one that arrives at once.
- R12: Asserting `rst_n` returns the block to the state described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| bist_fail | input | 5 | Self-test failure flags (see R4) |
| img_misalign | input | 1 | Initial memory image structure misaligned |
| bus_conf_fail | input | 1 | Bus confidence test failed |
| sys_err | input | 1 | Runtime system error |
| rd_ready | input | 1 | Bus accepts the read request |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read address carrying the fail code |
| fail_n | output | 1 | Active-low failure indication |
| halt | output | 1 | Block stopped; cleared only by reset |

## Verification
Two things can fall in the same cycle. The first is a self-test fault together with a non-self-test fault: the bench sweeps all 256 combinations of the eight fault inputs in one pulse and compares each captured address with a code computed from R4, R5 and R7. The second is a fresh fault arriving while a request is waiting for `rd_ready`: the bench drives the complemented fault pattern during a varied number of wait cycles and checks that the address holds. Acceptance and new faults are also driven together, to check that the block halts without starting a second read.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned NBIST    = 5;
  localparam logic [ADDR_W-CODE_W-1:0] ADDR_HI = 24'hFEFFFF;

  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_SEND  = 2'd1,
    ST_STOP  = 2'd2
  } rep_state_e;
endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fc_code_build.sv
module fc_code_build
  import fc_pkg::*;
(
  input  logic [NBIST-1:0]  bist_fail,
  input  logic              img_misalign,
  input  logic              bus_conf_fail,
  input  logic              sys_err,
  output logic              any_fault,
  output logic [CODE_W-1:0] code
);
  logic bist_any;
  logic other_any;

  always_comb begin
    bist_any  = |bist_fail;
    other_any = img_misalign | bus_conf_fail | sys_err;
    any_fault = bist_any | other_any;
    if (bist_any) begin
      // self-test form wins when both groups are pending
      code = {1'b1, bist_fail, 2'b00};
    end else begin
      code = {1'b0, 2'b11, img_misalign, sys_err, bus_conf_fail, 2'b00};
    end
  end
endmodule

// File: rtl/fc_report_fsm.sv
module fc_report_fsm
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_fault,
  input  logic [CODE_W-1:0] code_in,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fail_n,
  output logic              halt
);
  rep_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_q;
  logic              code_en;

  always_comb begin
    state_d = state_q;
    code_en = 1'b0;
    unique case (state_q)
      ST_WATCH: if (any_fault) begin
        state_d = ST_SEND;
        code_en = 1'b1;
      end
      ST_SEND:  if (rd_ready) state_d = ST_STOP;
      ST_STOP:  state_d = ST_STOP;
      default:  state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WATCH;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_in;
  end

  assign rd_valid = (state_q == ST_SEND);
  assign rd_addr  = {ADDR_HI, code_q};
  assign fail_n   = (state_q == ST_WATCH);
  assign halt     = (state_q == ST_STOP);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  // R9
  single_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && !rd_valid));
  // R9
  fail_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_n |=> !fail_n);
  // R2
  detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_n && any_fault) |=> (rd_valid && !fail_n));
  // R6
  reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[1:0] == 2'b00));
  // R3
  addr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[ADDR_W-1:CODE_W] == ADDR_HI));
endmodule

// File: rtl/syserr_fail_reporter.sv
module syserr_fail_reporter
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBIST-1:0]  bist_fail,
  input  logic              img_misalign,
  input  logic              bus_conf_fail,
  input  logic              sys_err,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              fail_n,
  output logic              halt
);
  logic              srst_n;
  logic              any_fault;
  logic [CODE_W-1:0] code;

  fc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fc_code_build u_code (
    .bist_fail     (bist_fail),
    .img_misalign  (img_misalign),
    .bus_conf_fail (bus_conf_fail),
    .sys_err       (sys_err),
    .any_fault     (any_fault),
    .code          (code)
  );

  fc_report_fsm u_fsm (
    .clk       (clk),
    .rst_n     (srst_n),
    .any_fault (any_fault),
    .code_in   (code),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .fail_n    (fail_n),
    .halt      (halt)
  );

  // R7
  bist_prio_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fail_n && (|bist_fail)) |=> rd_addr[7]);
endmodule

// File: tb/tb_syserr_fail_reporter.sv
module tb_syserr_fail_reporter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bist_fail;
  logic        img_misalign, bus_conf_fail, sys_err, rd_ready;
  logic        rd_valid, fail_n, halt;
  logic [31:0] rd_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syserr_fail_reporter dut (
    .clk(clk), .rst_n(rst_n), .bist_fail(bist_fail),
    .img_misalign(img_misalign), .bus_conf_fail(bus_conf_fail),
    .sys_err(sys_err), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .fail_n(fail_n), .halt(halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vec: [4:0] self-test flags, [5] misalign, [6] sys_err, [7] bus confidence
  task automatic drive(input logic [7:0] v);
    bist_fail     = v[4:0];
    img_misalign  = v[5];
    sys_err       = v[6];
    bus_conf_fail = v[7];
  endtask

  function automatic logic [31:0] exp_addr(input logic [7:0] v);
    logic [7:0] c;
    if (v[4:0] != 0) c = 8'h80 | ({3'b0, v[4:0]} << 2);           // R4 R7
    else c = 8'h60 | ({7'b0, v[5]} << 4) | ({7'b0, v[6]} << 3)
               | ({7'b0, v[7]} << 2);                               // R5
    return 32'hFEFFFF00 | {24'b0, c};                               // R3 R6
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(8'h00);
    rd_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 R12
    chk("R1", {29'b0, fail_n, rd_valid, halt}, 32'b100);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(8'h00);
    rd_ready = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      int idle;
      int waits;
      vb = v[7:0];
      idle = v % 5;
      waits = (v / 5) % 4;
      do_reset();
      repeat (idle) @(negedge clk);
      if (v % 7 == 0) rd_ready = 1'b1;  // ready already high before the request
      drive(vb);
      @(negedge clk);
      drive(8'h00);
      if (vb == 0) begin
        rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {29'b0, fail_n, rd_valid, halt}, 32'b100);
        continue;
      end
      // R2 R11
      chk("R2", {30'b0, fail_n, rd_valid}, 32'b01);
      chk("R3", rd_addr, exp_addr(vb));
      if (rd_ready) begin
        @(negedge clk);
        rd_ready = 1'b0;
      end else begin
        for (int w = 0; w < waits; w++) begin
          drive(~vb);
          @(negedge clk);
          // R8 R10
          chk("R8", {31'b0, rd_valid}, 32'b1);
          chk("R10", rd_addr, exp_addr(vb));
        end
        drive(8'h00);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
      end
      // R9
      chk("R9", {29'b0, fail_n, rd_valid, halt}, 32'b001);
      drive(8'hFF);
      rd_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9", {29'b0, fail_n, rd_valid, halt}, 32'b001);
      drive(8'h00);
      rd_ready = 1'b0;
    end
    // R12: reset in the middle of a pending request
    do_reset();
    drive(8'h40);
    @(negedge clk);
    drive(8'h00);
    chk("R5", rd_addr, 32'hFEFFFF68);
    do_reset();
    chk("R12", {31'b0, rd_valid}, 32'b0);
    done = 1;
  end

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule